// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the digital fault sequencer of a synchronous step-down regulator. It watches two comparator flags: one reports that the high-side switch has hit its peak current limit, and one reports that feedback has sagged below 70 % of the reference. When both flags stay set without a break for a programmable qualification time, the block treats the output as shorted. It stops switching, asks the analog side to discharge the compensation node and the soft-start/reference node, and holds that state for a fixed number of switching periods.

After the off interval the block lets the converter switch again for a short restart window. During that window a new short cannot be qualified. At the end of the window the fault flags are sampled once. A clear result returns the converter to normal regulation. A fault still present sends it back to the off interval. Enable and undervoltage lockout override every state and return the block to a cleared idle state.

Time is measured in two ways. The qualification time is counted in microseconds by an internal divider of the system clock. The off and restart intervals are counted in switching periods, supplied as a one-clock tick input. All outputs are decoded from one registered state, so every input effect appears at the outputs one clock edge after it is sampled.

Top module: `hiccup_ctrl`

## Requirements
- R1: In the running state, the block enters hiccup at the clock edge that samples the CLK_PER_US*QUAL_US-th consecutive cycle with both ilim_hit_i and fb_low_i high (9000 edges with the defaults 250 and 36).
- R2: While the block is off, sw_en_o=0, comp_dis_o=1, ss_dis_o=1 and hiccup_o=1.
- R3: The qualification count restarts from zero whenever ilim_hit_i or fb_low_i is sampled low for even a single cycle, so two shorter fault bursts never add up.
- R4: The off interval ends at the edge that samples the OFF_CYC-th high cyc_tick_i (default 896) counted from entry.
- R5: The restart window drives sw_en_o=1, comp_dis_o=0, ss_dis_o=0 and hiccup_o=1. It lasts RETRY_CYC ticks of cyc_tick_i (default 112), and fault qualification is blanked throughout.
- R6: At the edge that samples the last restart tick, the block goes back to the off interval if ilim_hit_i and fb_low_i are both high. Otherwise it resumes running with hiccup_o=0.
- R7: When en_i is low or uvlo_i is high at a clock edge, the block goes idle at that edge, with sw_en_o=0, comp_dis_o=1, ss_dis_o=1 and hiccup_o=0, and all of its counters are cleared.
- R8: From idle, the first edge with en_i high and uvlo_i low moves the block to running, with sw_en_o=1, comp_dis_o=0, ss_dis_o=0 and hiccup_o=0. Qualification counting starts at the following edge.
- R9: While rst_ni is low, the outputs show the idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| uvlo_i | input | 1 | Supply undervoltage lockout flag |
| cyc_tick_i | input | 1 | One-clock pulse per switching period |
| ilim_hit_i | input | 1 | High-side peak current limit comparator flag |
| fb_low_i | input | 1 | Feedback below 70 % of reference flag |
| sw_en_o | output | 1 | Power switches allowed to switch |
| comp_dis_o | output | 1 | Pull the compensation node low |
| ss_dis_o | output | 1 | Pull the soft-start/reference node low |
| hiccup_o | output | 1 | Hiccup off interval or restart window in progress |

## Verification
Some rules are checked on every cycle. The off state must hold until its tick count is reached. The restart window must never fall straight back into the off state before it ends. Entry into hiccup must follow a cycle with both fault flags high. A dropped flag must clear the qualification counter. Shutdown inputs must force the idle outputs on the next edge.

Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact qualification length in clocks and the off and restart durations in switching ticks. It also covers whether separate fault bursts are kept from adding up, the decision taken at the end of the restart window, and the fact that a full qualification time is needed again after an enable drop.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_OFF   = 2'd2,
    ST_RETRY = 2'd3
  } hic_state_e;
endpackage

// File: rtl/hiccup_qual_timer.sv
// Counts continuous fault time in microseconds; any gap clears it.
module hiccup_qual_timer #(
  parameter int DIV = 250,
  parameter int CNT = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic expire_o
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int UW = (CNT > 2) ? $clog2(CNT) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [UW-1:0] CNT_LAST = UW'(CNT - 1);

  logic [DW-1:0] div_q;
  logic [UW-1:0] us_q;
  logic          us_tick;

  assign us_tick  = arm_i && (div_q == DIV_LAST);
  assign expire_o = us_tick && (us_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      us_q  <= '0;
    end else if (!arm_i) begin
      div_q <= '0;
      us_q  <= '0;
    end else begin
      div_q <= us_tick ? '0 : div_q + 1'b1;
      if (us_tick) us_q <= us_q + 1'b1;
    end
  end

  assert_qual_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (div_q == '0 && us_q == '0));

endmodule

// File: rtl/hiccup_phase_timer.sv
// Counts switching ticks within the off and restart phases.
module hiccup_phase_timer #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] last_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_phase_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int OFF_CYC   = 896,
  parameter int RETRY_CYC = 112,
  parameter int PW        = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ok_i,
  input  logic          fault_i,
  input  logic          qual_expire_i,
  input  logic          phase_done_i,
  output hic_state_e    state_o,
  output logic          phase_clr_o,
  output logic [PW-1:0] phase_last_o
);
  localparam logic [PW-1:0] OFF_LAST   = PW'(OFF_CYC - 1);
  localparam logic [PW-1:0] RETRY_LAST = PW'(RETRY_CYC - 1);

  hic_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_ok_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_RUN;
        ST_RUN:   if (qual_expire_i) st_d = ST_OFF;
        ST_OFF:   if (phase_done_i)  st_d = ST_RETRY;
        ST_RETRY: if (phase_done_i)  st_d = fault_i ? ST_OFF : ST_RUN;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o      = st_q;
  assign phase_clr_o  = (st_d != st_q) || !(st_q inside {ST_OFF, ST_RETRY});
  assign phase_last_o = (st_q == ST_RETRY) ? RETRY_LAST : OFF_LAST;

  assert_entry_qual_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && $past(st_q) == ST_RUN) |-> $past(fault_i));

  assert_off_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && en_ok_i && !phase_done_i) |=> st_q == ST_OFF);

  assert_retry_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RETRY && !phase_done_i) |=> st_q != ST_OFF);

  assert_retry_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RETRY && phase_done_i && en_ok_i && !fault_i) |=> st_q == ST_RUN);

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int QUAL_US    = 36,
  parameter int OFF_CYC    = 896,
  parameter int RETRY_CYC  = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic cyc_tick_i,
  input  logic ilim_hit_i,
  input  logic fb_low_i,
  output logic sw_en_o,
  output logic comp_dis_o,
  output logic ss_dis_o,
  output logic hiccup_o
);
  localparam int MAX_CYC = (OFF_CYC > RETRY_CYC) ? OFF_CYC : RETRY_CYC;
  localparam int PW      = ($clog2(MAX_CYC) > 10) ? $clog2(MAX_CYC) : 10;

  hic_state_e    state;
  logic          en_ok, fault, qual_arm, qual_expire;
  logic          phase_clr, phase_done;
  logic [PW-1:0] phase_last;

  assign en_ok    = en_i && !uvlo_i;
  assign fault    = ilim_hit_i && fb_low_i;
  assign qual_arm = en_ok && fault && (state == ST_RUN);

  hiccup_qual_timer #(
    .DIV (CLK_PER_US),
    .CNT (QUAL_US)
  ) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (qual_arm),
    .expire_o (qual_expire)
  );

  hiccup_phase_timer #(
    .W (PW)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase_clr),
    .tick_i (cyc_tick_i),
    .last_i (phase_last),
    .done_o (phase_done)
  );

  hiccup_seq #(
    .OFF_CYC   (OFF_CYC),
    .RETRY_CYC (RETRY_CYC),
    .PW        (PW)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_ok_i       (en_ok),
    .fault_i       (fault),
    .qual_expire_i (qual_expire),
    .phase_done_i  (phase_done),
    .state_o       (state),
    .phase_clr_o   (phase_clr),
    .phase_last_o  (phase_last)
  );

  assign sw_en_o    = state inside {ST_RUN, ST_RETRY};
  assign comp_dis_o = state inside {ST_IDLE, ST_OFF};
  assign ss_dis_o   = state inside {ST_IDLE, ST_OFF};
  assign hiccup_o   = state inside {ST_OFF, ST_RETRY};

  assert_shutdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || uvlo_i) |=> (!sw_en_o && !hiccup_o && comp_dis_o && ss_dis_o));

  assert_off_discharge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiccup_o && !sw_en_o) |-> (comp_dis_o && ss_dis_o));

endmodule

// File: tb/hiccup_ctrl_bench.sv
module hiccup_ctrl_bench;
  localparam int P    = 25;
  localparam int Q    = 36;
  localparam int N    = P * Q;
  localparam int OFFC = 896;
  localparam int RETC = 112;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, uvlo = 1'b0, tick = 1'b0, ilim = 1'b0, fbl = 1'b0;
  logic sw_en, comp_dis, ss_dis, hiccup;
  int   checks = 0, fails = 0, cyc = 0, tc = 0;
  bit   chk_on = 1'b0;
  int   m_st = 0, m_q = 0, m_p = 0;

  always #2 clk = ~clk;

  hiccup_ctrl #(
    .CLK_PER_US (P),
    .QUAL_US    (Q),
    .OFF_CYC    (OFFC),
    .RETRY_CYC  (RETC)
  ) u_hiccup_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .uvlo_i     (uvlo),
    .cyc_tick_i (tick),
    .ilim_hit_i (ilim),
    .fb_low_i   (fbl),
    .sw_en_o    (sw_en),
    .comp_dis_o (comp_dis),
    .ss_dis_o   (ss_dis),
    .hiccup_o   (hiccup)
  );

  // switching tick: one clock in four
  always @(negedge clk) begin
    tc   = (tc == 3) ? 0 : tc + 1;
    tick = (tc == 3);
  end

  function automatic logic [3:0] exp_out(int st);
    case (st)
      0:       return 4'b0110;
      1:       return 4'b1000;
      2:       return 4'b0111;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic string st_tag(int st);
    case (st)
      0:       return "R7";
      1:       return "R8";
      2:       return "R2";
      default: return "R5";
    endcase
  endfunction

  // reference model built from the requirements
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st <= 0; m_q <= 0; m_p <= 0;
    end else if (!en || uvlo) begin
      m_st <= 0; m_q <= 0; m_p <= 0;
    end else begin
      case (m_st)
        0: begin m_st <= 1; m_q <= 0; m_p <= 0; end
        1: begin
          if (ilim && fbl) begin
            if (m_q + 1 == N) begin m_st <= 2; m_q <= 0; m_p <= 0; end
            else m_q <= m_q + 1;
          end else m_q <= 0;
        end
        2: if (tick) begin
          if (m_p + 1 == OFFC) begin m_st <= 3; m_p <= 0; end
          else m_p <= m_p + 1;
        end
        default: begin
          m_q <= 0;
          if (tick) begin
            if (m_p + 1 == RETC) begin m_st <= (ilim && fbl) ? 2 : 1; m_p <= 0; end
            else m_p <= m_p + 1;
          end
        end
      endcase
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) chk(st_tag(m_st), {sw_en, comp_dis, ss_dis, hiccup}, exp_out(m_st));
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      finish_run();
    end
  end

  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fault(logic v);
    ilim = v; fbl = v;
  endtask

  initial begin
    int k;
    int seed_dummy;
    seed_dummy = $urandom(32'd424242);
    // R9: reset state
    wn(3);
    chk("R9", {sw_en, comp_dis, ss_dis, hiccup}, 4'b0110);
    rst_ni = 1'b1;
    chk_on = 1'b1;
    wn(2);
    // R8: enable starts running one edge later
    en = 1'b1;
    wn(1);
    chk("R8", {sw_en, hiccup}, 2'b10);
    wn(5);

    // R1: exact qualification length
    set_fault(1'b1);
    k = 0;
    while (!hiccup && k < N + 10) begin wn(1); k++; end
    chk("R1", k, N);
    chk("R2", {sw_en, comp_dis, ss_dis, hiccup}, 4'b0111);

    // R4: off length in clocks, ticks every fourth clock
    k = 0;
    while (hiccup && !sw_en && k < 5000) begin wn(1); k++; end
    chk("R4", (k >= OFFC * 4 - 3 && k <= OFFC * 4) ? 1 : 0, 1);
    // R5: restart window length, fault still present and blanked
    k = 0;
    while (hiccup && sw_en && k < 1000) begin wn(1); k++; end
    chk("R5", (k >= RETC * 4 - 3 && k <= RETC * 4) ? 1 : 0, 1);
    // R6: fault persists at end of window -> off again
    chk("R6", {sw_en, hiccup}, 2'b01);
    set_fault(1'b0);
    k = 0;
    while (hiccup && k < 6000) begin wn(1); k++; end
    chk("R6", {sw_en, hiccup}, 2'b10);
    wn(10);

    // R3: bursts separated by a one-cycle drop of either flag do not add up
    set_fault(1'b1); wn(N - 1);
    fbl = 1'b0;      wn(1);
    fbl = 1'b1;      wn(N - 1);
    ilim = 1'b0;     wn(1);
    ilim = 1'b1;     wn(N - 1);
    set_fault(1'b0); wn(2);
    chk("R3", hiccup, 0);

    // R7: enable drop in off state, then full requalification
    set_fault(1'b1); wn(N + 100);
    en = 1'b0; wn(1);
    chk("R7", {sw_en, comp_dis, ss_dis, hiccup}, 4'b0110);
    en = 1'b1;
    k = 0;
    while (!hiccup && k < N + 10) begin wn(1); k++; end
    chk("R7", k, N + 1);
    // uvlo pulse mid qualification
    en = 1'b0; wn(2); en = 1'b1; wn(2);
    wn(N / 2);
    uvlo = 1'b1; wn(1);
    chk("R7", {sw_en, hiccup}, 2'b00);
    uvlo = 1'b0;
    wn(N - 5);
    chk("R7", hiccup, 0);
    set_fault(1'b0); wn(20);

    // random phase, checked by the model every cycle
    for (int it = 0; it < 6; it++) begin
      int len;
      len = N - 30 + int'($urandom_range(60));
      set_fault(1'b1); wn(len);
      set_fault(1'b0);
      for (int s = 0; s < 25; s++) begin
        ilim = ($urandom_range(2) == 0);
        fbl  = ($urandom_range(3) != 0);
        if ($urandom_range(15) == 0) begin uvlo = 1'b1; wn(1); uvlo = 1'b0; end
        wn(200);
      end
      set_fault(1'b0);
      k = 0;
      while (hiccup && k < 6000) begin wn(1); k++; end
      wn(5);
    end

    finish_run();
  end
endmodule